// File: doc/BRIEF.md
# Shader Operand Relative Address Resolver

This block turns the 7-bit source-operand code of a shader instruction into a register bank and an index within that bank. Relative indexing is optional. A 2-bit selector names one offset: one of two signed offset registers, or a loop-count value that arrives on a port. When a selector is given and the operand is a float constant, the offset is added to the constant index. Input and temporary operands never take an offset.

The block also holds the two signed offset registers. A move-to-offset operation loads them. It takes two single-precision floats, truncates each toward zero and saturates the result to the signed offset width. A 2-bit write mask chooses which registers take their new value. Operand resolution is purely combinational. A load takes effect at the clock edge, so the next instruction sees it.

Neither side has back-pressure. The resolver answers in the same cycle for any operand, and a load is accepted on every cycle in which `mova_en` is high. For this reason the block carries no valid/ready pair, and all pins are plain control and data.

Top module: `opnd_addr_resolver`

## Requirements
- R1: Codes 0x00–0x0F give bank 0 (input) with index code[3:0]. Codes 0x10–0x1F give bank 1 (temporary) with index code[3:0]. Codes 0x20–0x7F give bank 2 (float constant) with index code−0x20 when no offset applies.
- R2: For a constant operand, selector 0 adds nothing, 1 adds offset register X, 2 adds offset register Y and 3 adds `loop_cnt`, with all values signed. For example, code 0x28 with Y = 3 resolves to index 11.
- R3: For input and temporary operands the selector is ignored. The index stays code[3:0] and `out_of_range` stays 0.
- R4: A relative constant index wraps modulo 128. `out_of_range` is 1 exactly when the bank is 2 and the wrapped index is above 95.
- R5: A load converts each float to an integer by truncation toward zero. Values with magnitude below 1 give 0.
- R6: On a load, mask bit 0 enables the write of X from `mova_x` and mask bit 1 enables the write of Y from `mova_y`. A register whose mask bit is clear keeps its value. When `mova_en` is low, neither register changes.
- R7: Results beyond the signed 8-bit range saturate to 127 or −128. Infinities saturate the same way.
- R8: A NaN input loads 0.
- R9: A loaded value takes effect at the next rising clock edge. Operands resolved before that edge use the old value.
- R10: Reset (`rst_n` low) clears both offset registers to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_code | input | 7 | Source operand code |
| idx_sel | input | 2 | Relative index selector |
| loop_cnt | input | 8 | Signed loop-count offset |
| mova_en | input | 1 | Load offset registers this cycle |
| mova_mask | input | 2 | Per-register write mask (bit0 X, bit1 Y) |
| mova_x | input | 32 | Single-precision value for X |
| mova_y | input | 32 | Single-precision value for Y |
| bank_sel | output | 2 | Resolved bank (0 input, 1 temp, 2 constant) |
| reg_index | output | 7 | Resolved index in bank |
| out_of_range | output | 1 | Constant index beyond 95 |
| ofs_x | output | 8 | Offset register X |
| ofs_y | output | 8 | Offset register Y |

## Verification
The assertions assume that the load inputs are held stable across the clock edge. They also assume that `src_code` and `idx_sel` are settled whenever the combinational checks evaluate. The bench drives every input on the falling edge and samples after it has settled, so both assumptions hold. Random float stimulus keeps exponents near the saturation boundary, where truncation and clamping actually matter. NaN, the infinities and sub-unity values are mixed in as directed cases. Random operand codes cover all three banks with every selector value.

// File: rtl/opnd_pkg.sv
package opnd_pkg;
  localparam int CODE_W   = 7;
  localparam int SEL_W    = 2;
  localparam int FLT_W    = 32;
  localparam int BANK_W   = 2;
  localparam int NUM_IN   = 16;
  localparam int NUM_TMP  = 16;
  localparam int NUM_CNST = 96;
  localparam int TMP_BASE = NUM_IN;
  localparam int CNST_BASE = NUM_IN + NUM_TMP;

  typedef enum logic [BANK_W-1:0] {
    BANK_IN    = 2'd0,
    BANK_TMP   = 2'd1,
    BANK_CONST = 2'd2
  } bank_e;

  typedef enum logic [SEL_W-1:0] {
    SEL_NONE = 2'd0,
    SEL_X    = 2'd1,
    SEL_Y    = 2'd2,
    SEL_LOOP = 2'd3
  } sel_e;
endpackage

// File: rtl/opnd_f2i.sv
module opnd_f2i #(
  parameter int OFS_W = 8
) (
  input  logic [31:0]      fval,
  output logic [OFS_W-1:0] ival
);
  localparam int BIAS    = 127;
  localparam int SAT_EXP = BIAS + OFS_W - 1;
  localparam int MAN_W   = 23;
  localparam logic [OFS_W-1:0] POS_MAX = {1'b0, {(OFS_W-1){1'b1}}};
  localparam logic [OFS_W-1:0] NEG_MIN = {1'b1, {(OFS_W-1){1'b0}}};

  logic             sgn;
  logic [7:0]       expo;
  logic [MAN_W-1:0] man;
  logic             is_nan, is_sat, is_small;
  logic [MAN_W:0]   sig, shifted;
  logic [7:0]       sh;
  logic [OFS_W-1:0] mag;

  always_comb begin
    sgn      = fval[31];
    expo     = fval[30:23];
    man      = fval[MAN_W-1:0];
    is_nan   = (expo == 8'hFF) && (man != '0);
    is_sat   = !is_nan && (int'(expo) >= SAT_EXP);
    is_small = int'(expo) < BIAS;
    sig      = {1'b1, man};
    sh       = 8'(BIAS + MAN_W) - expo;
    shifted  = sig >> sh;
    mag      = shifted[OFS_W-1:0];
    if (is_nan || is_small)  ival = '0;
    else if (is_sat)         ival = sgn ? NEG_MIN : POS_MAX;
    else                     ival = sgn ? (~mag + 1'b1) : mag;
  end

  always_comb begin
    if (is_nan) AST_NAN_ZERO: assert (ival == '0);           // R8
    if (!is_nan && sgn) AST_NEG_NOT_POS: assert (!(ival != '0 && !ival[OFS_W-1])); // R5
    if (!is_nan && !sgn) AST_POS_NOT_NEG: assert (!ival[OFS_W-1]); // R7
  end
endmodule

// File: rtl/opnd_ofs_regs.sv
module opnd_ofs_regs #(
  parameter int OFS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [1:0]       load_mask,
  input  logic [31:0]      fval_x,
  input  logic [31:0]      fval_y,
  output logic [OFS_W-1:0] ofs_x,
  output logic [OFS_W-1:0] ofs_y
);
  logic [OFS_W-1:0] conv [2];
  logic [OFS_W-1:0] regs [2];
  logic [31:0]      fin  [2];

  assign fin[0] = fval_x;
  assign fin[1] = fval_y;

  for (genvar g = 0; g < 2; g++) begin : g_comp
    opnd_f2i #(.OFS_W(OFS_W)) u_f2i (.fval(fin[g]), .ival(conv[g]));
    always_ff @(posedge clk) begin
      if (!rst_n)                       regs[g] <= '0;
      else if (load_en && load_mask[g]) regs[g] <= conv[g];
    end
  end

  assign ofs_x = regs[0];
  assign ofs_y = regs[1];

  AST_X_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_en && load_mask[0]) |=> $stable(ofs_x));             // R6
  AST_Y_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_en && load_mask[1]) |=> $stable(ofs_y));             // R6
  AST_X_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && load_mask[0]) |=> ofs_x == $past(conv[0]));     // R9
  AST_Y_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && load_mask[1]) |=> ofs_y == $past(conv[1]));     // R9
endmodule

// File: rtl/opnd_decode.sv
module opnd_decode
  import opnd_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic [CODE_W-1:0] src_code,
  input  logic [SEL_W-1:0]  idx_sel,
  input  logic [OFS_W-1:0]  ofs_x,
  input  logic [OFS_W-1:0]  ofs_y,
  input  logic [OFS_W-1:0]  loop_cnt,
  output bank_e             bank,
  output logic [CODE_W-1:0] index,
  output logic              oor
);
  localparam int LOC_W = $clog2(NUM_IN);

  logic [OFS_W-1:0]  ofs;
  logic [CODE_W-1:0] base;

  always_comb begin
    case (sel_e'(idx_sel))
      SEL_X:    ofs = ofs_x;
      SEL_Y:    ofs = ofs_y;
      SEL_LOOP: ofs = loop_cnt;
      default:  ofs = '0;
    endcase
    if (int'(src_code) < TMP_BASE)       bank = BANK_IN;
    else if (int'(src_code) < CNST_BASE) bank = BANK_TMP;
    else                                 bank = BANK_CONST;
    base = src_code - CODE_W'(CNST_BASE);
    if (bank == BANK_CONST) begin
      index = base + CODE_W'(ofs);
      oor   = int'(index) >= NUM_CNST;
    end else begin
      index = {{(CODE_W-LOC_W){1'b0}}, src_code[LOC_W-1:0]};
      oor   = 1'b0;
    end
  end

  always_comb begin
    if (oor) AST_OOR_CONST_ONLY: assert (bank == BANK_CONST);        // R4
    if (bank != BANK_CONST) AST_LOCAL_PASS: assert (index[CODE_W-1:LOC_W] == '0); // R3
    if (idx_sel == '0) AST_NO_SEL_IN_RANGE: assert (!oor);            // R2
  end
endmodule

// File: rtl/opnd_addr_resolver.sv
module opnd_addr_resolver
  import opnd_pkg::*;
#(
  parameter int OFS_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        src_code,
  input  logic [1:0]        idx_sel,
  input  logic [OFS_W-1:0]  loop_cnt,
  input  logic              mova_en,
  input  logic [1:0]        mova_mask,
  input  logic [31:0]       mova_x,
  input  logic [31:0]       mova_y,
  output logic [1:0]        bank_sel,
  output logic [6:0]        reg_index,
  output logic              out_of_range,
  output logic [OFS_W-1:0]  ofs_x,
  output logic [OFS_W-1:0]  ofs_y
);
  bank_e bank;

  opnd_ofs_regs #(.OFS_W(OFS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .load_en(mova_en), .load_mask(mova_mask),
    .fval_x(mova_x), .fval_y(mova_y), .ofs_x(ofs_x), .ofs_y(ofs_y)
  );

  opnd_decode #(.OFS_W(OFS_W)) u_dec (
    .src_code(src_code), .idx_sel(idx_sel), .ofs_x(ofs_x), .ofs_y(ofs_y),
    .loop_cnt(loop_cnt), .bank(bank), .index(reg_index), .oor(out_of_range)
  );

  assign bank_sel = bank;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $rose(rst_n) |-> (ofs_x == '0 && ofs_y == '0));             // R10
endmodule

// File: tb/opnd_addr_resolver_bench.sv
`timescale 1ns/1ps
module opnd_addr_resolver_bench;
  logic clk = 0, rst_n = 0;
  logic [6:0] src_code = 0;
  logic [1:0] idx_sel = 0, mova_mask = 0;
  logic [7:0] loop_cnt = 0;
  logic mova_en = 0;
  logic [31:0] mova_x = 0, mova_y = 0;
  logic [1:0] bank_sel;
  logic [6:0] reg_index;
  logic out_of_range;
  logic [7:0] ofs_x, ofs_y;
  int checks = 0, errors = 0;
  int mx = 0, my = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  opnd_addr_resolver u_opnd_addr_resolver (.*);

  function automatic int f2i(bit [31:0] f);
    int e = int'(f[30:23]);
    real v;
    int t;
    if (e == 255) return (f[22:0] != 0) ? 0 : (f[31] ? -128 : 127);
    if (e == 0) return 0;
    v = (1.0 + real'(f[22:0]) / 8388608.0) * (2.0 ** (e - 127));
    if (v > 300.0) v = 300.0;
    if (f[31]) v = -v;
    t = $rtoi(v);
    if (t > 127) t = 127;
    if (t < -128) t = -128;
    return t;
  endfunction

  function automatic int sx8(logic [7:0] v);
    return int'($signed(v));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic resolve_check(logic [6:0] c, logic [1:0] s, logic [7:0] lc, string req);
    int eb, ei, eo, off;
    @(negedge clk);
    src_code = c; idx_sel = s; loop_cnt = lc;
    #1;
    off = (s == 1) ? mx : (s == 2) ? my : (s == 3) ? sx8(lc) : 0;
    if (c < 16) begin eb = 0; ei = c & 15; eo = 0; end
    else if (c < 32) begin eb = 1; ei = c & 15; eo = 0; end
    else begin eb = 2; ei = (int'(c) - 32 + off) & 127; eo = (ei > 95); end
    chk(bank_sel == eb, {req, " bank"}, bank_sel, eb);
    chk(reg_index == ei, {req, " index"}, reg_index, ei);
    chk(out_of_range == eo, {req, " oor"}, out_of_range, eo);
  endtask

  task automatic load(bit en, logic [1:0] m, logic [31:0] fx, logic [31:0] fy, string req);
    @(negedge clk);
    mova_en = en; mova_mask = m; mova_x = fx; mova_y = fy;
    @(posedge clk);
    if (en && m[0]) mx = f2i(fx);
    if (en && m[1]) my = f2i(fy);
    @(negedge clk);
    mova_en = 0;
    #1;
    chk(sx8(ofs_x) == mx, {req, " X"}, sx8(ofs_x), mx);
    chk(sx8(ofs_y) == my, {req, " Y"}, sx8(ofs_y), my);
  endtask

  function automatic logic [31:0] rnd_float();
    logic [31:0] f;
    int k = $urandom_range(0, 19);
    f[31] = $urandom_range(0, 1);
    f[22:0] = 23'($urandom);
    if (k == 0) f[30:23] = 8'hFF;
    else if (k == 1) f[30:0] = 31'h7F800000;
    else f[30:23] = 8'($urandom_range(118, 138));
    return f;
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    chk(ofs_x == 0, "R10 reset X", ofs_x, 0);
    chk(ofs_y == 0, "R10 reset Y", ofs_y, 0);
    resolve_check(7'h05, 0, 0, "R1 input");
    resolve_check(7'h1A, 0, 0, "R1 temp");
    resolve_check(7'h7F, 0, 0, "R1 c95");
    load(1, 2'b10, 32'h0, 32'h40400000, "R6 Y only 3.0");
    resolve_check(7'h28, 2, 0, "R2 c8+Y");
    chk(reg_index == 11, "R2 c11", reg_index, 11);
    resolve_check(7'h05, 3, 8'd7, "R3 input ignores loop");
    resolve_check(7'h13, 2, 0, "R3 temp ignores Y");
    load(1, 2'b01, 32'hBF800000, 32'h41200000, "R6 X only -1.0");
    resolve_check(7'h20, 1, 0, "R4 c0-1 wrap");
    resolve_check(7'h7F, 3, 8'd1, "R4 c95+1");
    load(1, 2'b11, 32'hC0200000, 32'h3F400000, "R5 -2.5 and 0.75");
    load(1, 2'b11, 32'h7FC00000, 32'h7F800000, "R8 NaN / R7 +inf");
    load(1, 2'b11, 32'hFF800000, 32'h447A0000, "R7 -inf / 1000.0");
    load(0, 2'b11, 32'h40000000, 32'h40000000, "R6 disabled");
    // R9: value loaded at edge not visible before it
    load(1, 2'b01, 32'h40A00000, 32'h0, "R9 X=5");
    @(negedge clk);
    mova_en = 1; mova_mask = 2'b01; mova_x = 32'h41000000; src_code = 7'h20; idx_sel = 1;
    #1;
    chk(reg_index == 5, "R9 old value before edge", reg_index, 5);
    @(posedge clk); mx = 8;
    @(negedge clk); mova_en = 0; #1;
    chk(reg_index == 8, "R9 new value after edge", reg_index, 8);
    for (int i = 0; i < 300; i++) begin
      load($urandom_range(0, 3) != 0, 2'($urandom), rnd_float(), rnd_float(), "R5 R7 random load");
      resolve_check(7'($urandom), 2'($urandom), 8'($urandom), "R2 R4 random resolve");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule